// File: doc/BRIEF.md
# SPI Micro-Operation Queue Master

This block is an SPI master for serial-NAND style transactions. Software does not start one byte shift at a time. It builds a transaction as a sequence of short micro-operations. Each micro-operation carries a 5-bit code and a 9-bit byte count.

One code lowers chip-select and another raises it. A third shifts a counted run of bytes from a byte-wide transmit FIFO onto MOSI. A fourth clocks a counted run of bytes in from MISO and stores each one in a byte-wide receive FIFO. The micro-operations wait in a small in-order queue and run only while the manual-enable input is set.

A register-style port serves all three queues:
- An operation-word write latches a word, and a separate strobe pushes the latched word into the queue.
- Strobes push transmit bytes and pop receive bytes.
- Full and empty flags are visible for all three queues.
- An idle flag reports that everything queued has finished.

The bus runs in SPI mode 0, MSB first. SCLK runs at half the system clock.

Top module: `spi_uop_engine`

## Requirements
- R1: `op_wr_i` latches `op_word_i`, with bits 8:0 as the byte count and bits 13:9 as the code. `op_push_i` enqueues the latched word, not the live input.
- R2: Code 0x01 drives `cs_no` low and code 0x00 drives it high. The count field of these codes has no effect.
- R3: Code 0x08 shifts count bytes from the transmit FIFO onto MOSI, MSB first, in mode 0. SCLK idles low and each bit takes one low and one high system cycle. MOSI changes only when SCLK falls.
- R4: Code 0x0C clocks count bytes in from MISO, sampled on the SCLK rising edge, MSB first, and pushes each byte into the receive FIFO. `rx_data_o` shows the head byte and `rx_pop_i` advances to the next byte.
- R5: The operation queue holds 4 entries and runs them strictly in order. `op_full_o` is set at 4 entries, and a push while full is dropped. `op_empty_o` rises once the last entry has been taken for execution.
- R6: A transmit micro-operation that finds the transmit FIFO empty holds SCLK low until a byte arrives, then continues.
- R7: A receive micro-operation does not start a byte while the receive FIFO is full. It resumes after a pop.
- R8: While `manual_en_i` is low, no micro-operation is taken from the queue and the bus pins hold their state.
- R9: `idle_o` is 1 exactly when the operation queue is empty and no micro-operation is in progress.
- R10: Three kinds of micro-operation are consumed with no SCLK activity and no FIFO access: a transmit with count 0, a receive with count 0, and any unknown code.
- R11: After reset, `cs_no` is 1, `sclk_o` is 0, all three queues are empty and `idle_o` is 1.
- R12: The transmit and receive FIFOs each hold 8 bytes. A push into a full transmit FIFO is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| manual_en_i | input | 1 | Lets the queue drive the bus |
| op_word_i | input | 14 | Micro-operation word: code in 13:9, count in 8:0 |
| op_wr_i | input | 1 | Latches op_word_i |
| op_push_i | input | 1 | Enqueues the latched word |
| op_full_o | output | 1 | Operation queue full |
| op_empty_o | output | 1 | Operation queue empty |
| tx_data_i | input | 8 | Transmit byte |
| tx_push_i | input | 1 | Pushes tx_data_i |
| tx_full_o | output | 1 | Transmit FIFO full |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| rx_data_o | output | 8 | Head byte of the receive FIFO |
| rx_pop_i | input | 1 | Advances to the next receive byte |
| rx_full_o | output | 1 | Receive FIFO full |
| rx_empty_o | output | 1 | Receive FIFO empty |
| idle_o | output | 1 | Queue empty and no micro-operation active |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | Chip-select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench goes after the stall paths:
- A transmit run with no data queued is watched for stray SCLK pulses. A design that clocked on regardless would send garbage bytes.
- A 9-byte receive run is sized to overfill the 8-entry receive FIFO. It catches a design that drops or overwrites the ninth byte instead of pausing.

It covers the edges of queue capacity:
- A fifth operation pushed into the full queue is shown to be dropped by the final chip-select level it would have changed.
- A ninth transmit byte is shown to be dropped by the transmit FIFO still reading empty afterwards.

It covers codes that must do nothing:
- Zero-count and unknown codes must leave the transmit FIFO and SCLK untouched. A decoder that treated count 0 as 512 would hang or clock.

It covers the latched operation word:
- The live `op_word_i` is corrupted before each strobe, so a design that enqueues the live input runs the wrong operation.

// File: rtl/spi_uop_pkg.sv
package spi_uop_pkg;
  localparam int CNT_W  = 9;
  localparam int CODE_W = 5;
  localparam int OPW_W  = CNT_W + CODE_W;

  localparam logic [CODE_W-1:0] OP_CS_HI = 5'h00;
  localparam logic [CODE_W-1:0] OP_CS_LO = 5'h01;
  localparam logic [CODE_W-1:0] OP_TX    = 5'h08;
  localparam logic [CODE_W-1:0] OP_RX    = 5'h0C;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  len;
  } uop_t;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_LOW, S_HIGH} exec_st_e;
endpackage

// File: rtl/uop_fifo.sv
module uop_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic push_ok, pop_ok;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  // full queue drops a lone push (R5 for the op queue, R12 for data)
  assert_full_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(wp_q)));

  assert_empty_pop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> (empty_o && $stable(rp_q)));
endmodule

// File: rtl/uop_exec.sv
module uop_exec
  import spi_uop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  uop_t       op_i,
  input  logic       op_empty_i,
  output logic       op_pop_o,
  input  logic [7:0] tx_data_i,
  input  logic       tx_empty_i,
  output logic       tx_pop_o,
  input  logic       rx_full_i,
  output logic [7:0] rx_data_o,
  output logic       rx_push_o,
  output logic       busy_o,
  output logic       sclk_o,
  output logic       cs_no,
  output logic       mosi_o,
  input  logic       miso_i
);
  exec_st_e         st_q;
  logic             is_tx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic             sclk_q, cs_q, mosi_q;

  assign op_pop_o  = (st_q == S_IDLE) && en_i && !op_empty_i;
  assign tx_pop_o  = (st_q == S_LOAD) && is_tx_q && !tx_empty_i;
  assign rx_push_o = (st_q == S_HIGH) && !is_tx_q && (bit_q == 3'd7);
  assign rx_data_o = sh_q;
  assign busy_o    = (st_q != S_IDLE);
  assign sclk_o    = sclk_q;
  assign cs_no     = cs_q;
  assign mosi_o    = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      is_tx_q <= 1'b0;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      mosi_q  <= 1'b1;
    end else begin
      unique case (st_q)
        S_IDLE: if (op_pop_o) begin
          if (op_i.code == OP_CS_LO) cs_q <= 1'b0;
          else if (op_i.code == OP_CS_HI) cs_q <= 1'b1;
          else if ((op_i.code == OP_TX || op_i.code == OP_RX) && op_i.len != '0) begin
            is_tx_q <= (op_i.code == OP_TX);
            cnt_q   <= op_i.len;
            st_q    <= S_LOAD;
          end
        end
        S_LOAD: begin
          // stall here: no data to send, or no room for a received byte
          if (is_tx_q && !tx_empty_i) begin
            sh_q   <= tx_data_i;
            mosi_q <= tx_data_i[7];
            bit_q  <= '0;
            st_q   <= S_LOW;
          end else if (!is_tx_q && !rx_full_i) begin
            sh_q   <= '0;
            mosi_q <= 1'b1;
            bit_q  <= '0;
            st_q   <= S_LOW;
          end
        end
        S_LOW: begin
          sclk_q <= 1'b1;
          sh_q   <= {sh_q[6:0], miso_i};
          st_q   <= S_HIGH;
        end
        S_HIGH: begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            cnt_q <= cnt_q - 1'b1;
            st_q  <= (cnt_q == CNT_W'(1)) ? S_IDLE : S_LOAD;
          end else begin
            bit_q <= bit_q + 1'b1;
            if (is_tx_q) mosi_q <= sh_q[7];
            st_q  <= S_LOW;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_mode0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));

  assert_sclk_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |=> $fell(sclk_o));

  assert_rx_room_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> !rx_full_i);

  assert_tx_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_LOAD && is_tx_q && tx_empty_i) |=> !sclk_o);

  assert_noop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_pop_o && op_i.len == '0) |=> (st_q == S_IDLE));
endmodule

// File: rtl/spi_uop_engine.sv
module spi_uop_engine
  import spi_uop_pkg::*;
#(
  parameter int OP_DEPTH   = 4,
  parameter int DATA_DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             manual_en_i,
  input  logic [OPW_W-1:0] op_word_i,
  input  logic             op_wr_i,
  input  logic             op_push_i,
  output logic             op_full_o,
  output logic             op_empty_o,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_push_i,
  output logic             tx_full_o,
  output logic             tx_empty_o,
  output logic [7:0]       rx_data_o,
  input  logic             rx_pop_i,
  output logic             rx_full_o,
  output logic             rx_empty_o,
  output logic             idle_o,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             mosi_o,
  input  logic             miso_i
);
  logic [OPW_W-1:0] op_word_q;
  logic [OPW_W-1:0] op_head;
  logic op_pop, tx_pop, rx_push, busy;
  logic [7:0] tx_head, rx_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) op_word_q <= '0;
    else if (op_wr_i) op_word_q <= op_word_i;
  end

  uop_fifo #(.W(OPW_W), .DEPTH(OP_DEPTH)) u_opq (
    .clk_i, .rst_ni, .push_i(op_push_i), .wdata_i(op_word_q), .pop_i(op_pop),
    .rdata_o(op_head), .full_o(op_full_o), .empty_o(op_empty_o));

  uop_fifo #(.W(8), .DEPTH(DATA_DEPTH)) u_txq (
    .clk_i, .rst_ni, .push_i(tx_push_i), .wdata_i(tx_data_i), .pop_i(tx_pop),
    .rdata_o(tx_head), .full_o(tx_full_o), .empty_o(tx_empty_o));

  uop_fifo #(.W(8), .DEPTH(DATA_DEPTH)) u_rxq (
    .clk_i, .rst_ni, .push_i(rx_push), .wdata_i(rx_byte), .pop_i(rx_pop_i),
    .rdata_o(rx_data_o), .full_o(rx_full_o), .empty_o(rx_empty_o));

  uop_exec u_exec (
    .clk_i, .rst_ni, .en_i(manual_en_i), .op_i(uop_t'(op_head)),
    .op_empty_i(op_empty_o), .op_pop_o(op_pop),
    .tx_data_i(tx_head), .tx_empty_i(tx_empty_o), .tx_pop_o(tx_pop),
    .rx_full_i(rx_full_o), .rx_data_o(rx_byte), .rx_push_o(rx_push),
    .busy_o(busy), .sclk_o, .cs_no, .mosi_o, .miso_i);

  assign idle_o = op_empty_o && !busy;

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !sclk_o);

  assert_hold_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!manual_en_i && idle_o) |=> ($stable(cs_no) && !sclk_o));
endmodule

// File: tb/spi_uop_engine_test.sv
module spi_uop_engine_test;
  logic clk = 0, rst_n = 0;
  logic manual_en_i = 0, op_wr_i = 0, op_push_i = 0;
  logic [13:0] op_word_i = '0;
  logic [7:0] tx_data_i = '0;
  logic tx_push_i = 0, rx_pop_i = 0;
  logic op_full_o, op_empty_o, tx_full_o, tx_empty_o, rx_full_o, rx_empty_o;
  logic [7:0] rx_data_o;
  logic idle_o, sclk_o, cs_no, mosi_o, miso_i;

  int checks = 0, errors = 0;
  int rises = 0, cap_n = 0, m_bit = 0, s_bit = 0, s_idx = 0;
  logic [7:0] m_sh = '0, s_sh;
  logic [7:0] cap [128];

  always #4 clk = ~clk;

  spi_uop_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .manual_en_i, .op_word_i, .op_wr_i, .op_push_i,
    .op_full_o, .op_empty_o, .tx_data_i, .tx_push_i, .tx_full_o, .tx_empty_o,
    .rx_data_o, .rx_pop_i, .rx_full_o, .rx_empty_o, .idle_o, .sclk_o, .cs_no,
    .mosi_o, .miso_i);

  function automatic logic [7:0] pat(int i);
    logic [31:0] t;
    t = i * 53;
    return t[7:0] ^ 8'hA5;
  endfunction

  initial s_sh = pat(0);
  assign miso_i = s_sh[7];

  // slave model: MISO shifts on falling SCLK, MOSI captured on rising SCLK
  always @(negedge sclk_o) if (rst_n) begin
    if (s_bit == 7) begin
      s_bit = 0; s_idx = s_idx + 1; s_sh = pat(s_idx);
    end else begin
      s_bit = s_bit + 1; s_sh = s_sh << 1;
    end
  end

  always @(posedge sclk_o) if (rst_n) begin
    rises = rises + 1;
    m_sh = {m_sh[6:0], mosi_o};
    m_bit = m_bit + 1;
    if (m_bit == 8) begin
      cap[cap_n % 128] = m_sh; cap_n = cap_n + 1; m_bit = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1: word latched by op_wr_i, live input corrupted before the push strobe
  task automatic push_op(input logic [4:0] code, input logic [8:0] n);
    @(negedge clk); op_word_i = {code, n}; op_wr_i = 1;
    @(negedge clk); op_wr_i = 0; op_word_i = 14'h3FFF; op_push_i = 1;
    @(negedge clk); op_push_i = 0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_data_i = b; tx_push_i = 1;
    @(negedge clk); tx_push_i = 0;
  endtask

  task automatic pop_rx(input logic [7:0] exp, input string req);
    @(negedge clk); chk(rx_data_o == exp, req, rx_data_o, exp);
    rx_pop_i = 1; @(negedge clk); rx_pop_i = 0;
  endtask

  task automatic wait_idle();
    int t = 0;
    @(negedge clk);
    while (!idle_o && t < 5000) begin @(negedge clk); t++; end
    if (t >= 5000) chk(0, "R9 idle timeout", 0, 1);
  endtask

  // {is_rx, count[8:0], seed[7:0]}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 9'd1, 8'h3C}, {1'b0, 9'd3, 8'h81}, {1'b1, 9'd2, 8'h00},
    {1'b0, 9'd5, 8'hF0}, {1'b1, 9'd4, 8'h00}, {1'b1, 9'd1, 8'h00}};

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base_r, base_c, base_i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(cs_no == 1 && sclk_o == 0, "R11 bus", {cs_no, sclk_o}, 2'b10);
    chk(op_empty_o && tx_empty_o && rx_empty_o && idle_o, "R11 empty/idle",
        {op_empty_o, tx_empty_o, rx_empty_o, idle_o}, 4'hF);

    // R8 disabled: op stays queued, bus unchanged
    push_op(5'h01, 9'd1);
    repeat (20) @(negedge clk);
    chk(!op_empty_o && cs_no && !idle_o, "R8 held", {op_empty_o, cs_no, idle_o}, 3'b010);
    manual_en_i = 1;
    wait_idle();
    chk(cs_no == 0 && op_empty_o, "R8/R2 cs low after enable", cs_no, 0);

    // R2 count field ignored on release
    push_op(5'h00, 9'd5);
    wait_idle();
    chk(cs_no == 1, "R2 cs release", cs_no, 1);

    // R5 queue depth, order, drop on full
    manual_en_i = 0;
    push_op(5'h01, 9'd1); push_op(5'h00, 9'd1);
    push_op(5'h01, 9'd1); push_op(5'h00, 9'd1);
    @(negedge clk);
    chk(op_full_o == 1, "R5 full at 4", op_full_o, 1);
    push_op(5'h01, 9'd1);
    manual_en_i = 1;
    wait_idle();
    chk(cs_no == 1, "R5 fifth dropped, in order", cs_no, 1);
    chk(op_empty_o == 1, "R5 empty after drain", op_empty_o, 1);

    // table of transfers: R3 transmit, R4 receive
    for (int v = 0; v < 6; v++) begin
      bit is_rx;
      logic [8:0] n;
      logic [7:0] seed;
      is_rx = VEC[v][17]; n = VEC[v][16:8]; seed = VEC[v][7:0];
      base_c = cap_n; base_i = s_idx; base_r = rises;
      if (!is_rx) for (int k = 0; k < int'(n); k++) push_tx(seed + 8'(k * 31));
      push_op(5'h01, 9'd1);
      push_op(is_rx ? 5'h0C : 5'h08, n);
      push_op(5'h00, 9'd1);
      wait_idle();
      chk(cs_no == 1, "R2 cs high after frame", cs_no, 1);
      chk(rises - base_r == 8 * int'(n), "R1 R3 sclk count", rises - base_r, 8 * n);
      if (is_rx) begin
        for (int k = 0; k < int'(n); k++) pop_rx(pat(base_i + k), "R4 rx byte");
      end else begin
        for (int k = 0; k < int'(n); k++)
          chk(cap[(base_c + k) % 128] == seed + 8'(k * 31), "R3 tx byte",
              cap[(base_c + k) % 128], seed + 8'(k * 31));
      end
    end

    // R6 transmit stall on empty FIFO
    base_r = rises; base_c = cap_n;
    push_op(5'h08, 9'd2);
    repeat (30) @(negedge clk);
    chk(rises == base_r, "R6 no sclk while tx empty", rises - base_r, 0);
    chk(idle_o == 0, "R9 busy while stalled", idle_o, 0);
    push_tx(8'hAA); push_tx(8'h55);
    wait_idle();
    chk(cap[base_c % 128] == 8'hAA && cap[(base_c + 1) % 128] == 8'h55, "R6 resumed data",
        {cap[base_c % 128], cap[(base_c + 1) % 128]}, 16'hAA55);

    // R7 receive stall on full FIFO
    base_r = rises; base_i = s_idx;
    push_op(5'h0C, 9'd9);
    repeat (200) @(negedge clk);
    chk(rx_full_o == 1, "R12 rx full at 8", rx_full_o, 1);
    chk(rises - base_r == 64, "R7 stalled after 8 bytes", rises - base_r, 64);
    chk(idle_o == 0, "R9 busy while rx stalled", idle_o, 0);
    pop_rx(pat(base_i), "R7 first byte");
    wait_idle();
    chk(rises - base_r == 72, "R7 resumed ninth byte", rises - base_r, 72);
    for (int k = 1; k < 9; k++) pop_rx(pat(base_i + k), "R7 rx byte");
    chk(rx_empty_o == 1, "R4 rx drained", rx_empty_o, 1);

    // R10 zero counts and unknown code
    push_tx(8'h77);
    base_r = rises; base_c = cap_n;
    push_op(5'h08, 9'd0); push_op(5'h1F, 9'd3); push_op(5'h0C, 9'd0);
    wait_idle();
    chk(rises == base_r, "R10 no sclk", rises - base_r, 0);
    chk(tx_empty_o == 0 && rx_empty_o == 1 && cs_no == 1, "R10 fifos untouched",
        {tx_empty_o, rx_empty_o, cs_no}, 3'b011);
    push_op(5'h08, 9'd1);
    wait_idle();
    chk(cap[base_c % 128] == 8'h77, "R10 byte still queued", cap[base_c % 128], 8'h77);

    // R12 transmit FIFO full, ninth push dropped
    base_c = cap_n;
    for (int k = 0; k < 9; k++) push_tx(8'h10 + 8'(k));
    chk(tx_full_o == 1, "R12 tx full", tx_full_o, 1);
    push_op(5'h08, 9'd8);
    wait_idle();
    chk(tx_empty_o == 1, "R12 ninth dropped", tx_empty_o, 1);
    for (int k = 0; k < 8; k++)
      chk(cap[(base_c + k) % 128] == 8'h10 + 8'(k), "R12 tx byte",
          cap[(base_c + k) % 128], 8'h10 + 8'(k));
    chk(idle_o == 1 && sclk_o == 0, "R9 idle at end", {idle_o, sclk_o}, 2'b10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule